// File: doc/BRIEF.md
# Dual-Port Two-Beat Burst SRAM Core

This block is a synchronous static memory with one read data path and one write data path. The two paths share a single address bus by splitting it in time. It runs on one fabric clock at twice the memory clock rate. An input phase flag tells the core which half of the memory clock the coming edge belongs to. A high flag marks the rising half, called the K edge. A low flag marks the opposite half, called the K# edge.

The read port takes its address on K edges and the write port takes its address on K# edges, so both ports can start one access in every memory cycle. Every storage location holds a pair of words that always move as a two-beat burst, one word per phase, in both directions. The read and write paths are separate wires, so moving from reads to writes never costs a turnaround cycle.

The write path is a two-state machine. WR_IDLE goes to WR_BEAT1 on a K# edge where the write select is low, and there it captures the address and the first word. WR_BEAT1 goes back to WR_IDLE on the next K edge, where it captures the second word into a holding register. The holding register is written into the array on the K# edge that follows. The read output is a three-state machine. OUT_IDLE goes to OUT_BEAT0 on a K# edge when a fetched read is waiting. OUT_BEAT0 always goes to OUT_BEAT1 on the next K edge. OUT_BEAT1 goes to OUT_BEAT0 on a K# edge if another fetched read is waiting, and otherwise to OUT_IDLE. If the read address matches a completed write that is still in the holding register, the fetch takes the holding register instead of the array.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is held, and after it is released with no read issued, `rvalid` is 0 and `rdata` is all zeros.
- R2: A read request is an edge where `k_phase`=1 and `rd_sel_n`=0, and that edge also captures the read address. A low `rd_sel_n` on an edge where `k_phase`=0 starts no read and produces no `rvalid`.
- R3: A write request is an edge where `k_phase`=0 and `wr_sel_n`=0. That edge captures the write address and word 0, and the next edge (`k_phase`=1) captures word 1. A low `wr_sel_n` on an edge where `k_phase`=1 changes no stored data. `k_phase` must alternate on every clock edge.
- R4: A read sampled on edge E sets `rvalid` high after edge E+3 and after edge E+4, and at no other time.
- R5: A location holds a pair of words. Word 0 is the word received on the K# edge and word 1 is the word received on the K edge. A read returns word 0 after edge E+3 and word 1 after edge E+4.
- R6: A read sampled on the same edge that delivers word 1 of a write to the same address returns the newly written pair.
- R7: A write whose address phase comes after a read's sampling edge is not seen by that read, even when both use the same address.
- R8: A read and a write started in the same memory cycle to different addresses are both completed correctly.
- R9: Reads issued on consecutive K edges keep `rvalid` high without a gap and return their beats in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, at twice the memory clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| k_phase | input | 1 | 1: this edge is a K edge (read address and write word 1). 0: this edge is a K# edge (write address and word 0) |
| addr | input | AW | Shared address bus, split in time between the two ports |
| rd_sel_n | input | 1 | Active-low read select, sampled on K edges |
| wr_sel_n | input | 1 | Active-low write select, sampled on K# edges |
| wdata | input | W | Write data, one word per phase |
| rdata | output | W | Read data, one word per phase |
| rvalid | output | 1 | High while `rdata` holds a read beat |

## Verification
A wrong state in the write machine shows up as a pair of words stored with the halves swapped or at the wrong address. It appears at the ports on the first later read of that location, which is at most a few memory cycles later in the sweep. A stale holding register or a wrong bypass compare shows up within one read latency as old data on the R6 reads, or as new data on the R7 reads. A wrong output-machine state shows up on the very next edge as a missing or extra `rvalid` beat, or as the two beats in the wrong order.

// File: rtl/qbs_pkg.sv
package qbs_pkg;

    typedef enum logic {
        WR_IDLE,
        WR_BEAT1
    } wr_state_t;

    typedef enum logic [1:0] {
        OUT_IDLE,
        OUT_BEAT0,
        OUT_BEAT1
    } out_state_t;

endpackage

// File: rtl/qbs_wr_path.sv
module qbs_wr_path
    import qbs_pkg::*;
#(
    parameter int AW = 6,
    parameter int W  = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            k_phase,
    input  logic [AW-1:0]   addr,
    input  logic            wr_sel_n,
    input  logic [W-1:0]    wdata,
    output logic            hold_v,
    output logic [AW-1:0]   hold_a,
    output logic [2*W-1:0]  hold_d
);
    localparam int PW = 2 * W;

    wr_state_t       wst, wst_nx;
    logic [AW-1:0]   wa_q;
    logic [W-1:0]    wd0_q;
    logic            start_w, finish_w;

    assign start_w  = (wst == WR_IDLE) && !k_phase && !wr_sel_n;
    assign finish_w = (wst == WR_BEAT1) && k_phase;

    always_ff @(posedge clk) begin
        if (!rst_n) wst <= WR_IDLE;
        else        wst <= wst_nx;
    end

    always_comb begin
        wst_nx = wst;
        unique case (wst)
            WR_IDLE:  if (start_w)  wst_nx = WR_BEAT1;
            WR_BEAT1: if (finish_w) wst_nx = WR_IDLE;
            default:  wst_nx = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wa_q   <= '0;
            wd0_q  <= '0;
            hold_v <= 1'b0;
            hold_a <= '0;
            hold_d <= '0;
        end else begin
            if (start_w) begin
                wa_q  <= addr;
                wd0_q <= wdata;
            end
            if (finish_w) begin
                hold_v <= 1'b1;
                hold_a <= wa_q;
                hold_d <= PW'({wdata, wd0_q});
            end else if (!k_phase) begin
                hold_v <= 1'b0;
            end
        end
    end

    // R3
    beat1_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wst == WR_BEAT1) |-> k_phase);

endmodule

// File: rtl/qbs_array.sv
module qbs_array #(
    parameter int AW = 6,
    parameter int W  = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            k_phase,
    input  logic            hold_v,
    input  logic [AW-1:0]   hold_a,
    input  logic [2*W-1:0]  hold_d,
    input  logic [AW-1:0]   rd_a,
    output logic [2*W-1:0]  rd_pair
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = 2 * W;

    logic [PW-1:0] mem [DEPTH];
    logic          commit;
    logic          hit;

    assign commit = hold_v && !k_phase;
    assign hit    = hold_v && (hold_a == rd_a);

    always_ff @(posedge clk) begin
        if (commit) mem[hold_a] <= hold_d;
    end

    always_comb begin
        rd_pair = hit ? hold_d : mem[rd_a];
    end

    // R3
    commit_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_v |-> !k_phase);

endmodule

// File: rtl/qbs_rd_path.sv
module qbs_rd_path
    import qbs_pkg::*;
#(
    parameter int AW = 6,
    parameter int W  = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            k_phase,
    input  logic [AW-1:0]   addr,
    input  logic            rd_sel_n,
    output logic [AW-1:0]   rd_a,
    input  logic [2*W-1:0]  rd_pair,
    output logic [W-1:0]    rdata,
    output logic            rvalid
);
    localparam int PW = 2 * W;

    out_state_t     ost, ost_nx;
    logic           rq_v, f_v;
    logic [PW-1:0]  f_pair;
    logic [W-1:0]   hi_q;

    assign rd_a = rd_a_q;
    logic [AW-1:0] rd_a_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_v   <= 1'b0;
            rd_a_q <= '0;
            f_v    <= 1'b0;
            f_pair <= '0;
        end else if (k_phase) begin
            rq_v   <= !rd_sel_n;
            rd_a_q <= addr;
        end else begin
            f_v    <= rq_v;
            f_pair <= rd_pair;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ost <= OUT_IDLE;
        else        ost <= ost_nx;
    end

    always_comb begin
        ost_nx = OUT_IDLE;
        unique case (ost)
            OUT_IDLE, OUT_BEAT1:
                ost_nx = (!k_phase && f_v) ? OUT_BEAT0 : OUT_IDLE;
            OUT_BEAT0:
                ost_nx = OUT_BEAT1;
            default:
                ost_nx = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            hi_q   <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= (ost_nx != OUT_IDLE);
            if (ost_nx == OUT_BEAT0) begin
                rdata <= f_pair[W-1:0];
                hi_q  <= f_pair[PW-1:W];
            end else if (ost_nx == OUT_BEAT1) begin
                rdata <= hi_q;
            end
        end
    end

    // R4
    beat0_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ost == OUT_BEAT0) |-> k_phase);

endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
    parameter int AW = 6,
    parameter int W  = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            k_phase,
    input  logic [AW-1:0]   addr,
    input  logic            rd_sel_n,
    input  logic            wr_sel_n,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    rdata,
    output logic            rvalid
);
    logic            hold_v;
    logic [AW-1:0]   hold_a;
    logic [2*W-1:0]  hold_d;
    logic [AW-1:0]   rd_a;
    logic [2*W-1:0]  rd_pair;

    qbs_wr_path #(.AW(AW), .W(W)) u_wr (
        .clk(clk), .rst_n(rst_n), .k_phase(k_phase), .addr(addr),
        .wr_sel_n(wr_sel_n), .wdata(wdata),
        .hold_v(hold_v), .hold_a(hold_a), .hold_d(hold_d)
    );

    qbs_array #(.AW(AW), .W(W)) u_arr (
        .clk(clk), .rst_n(rst_n), .k_phase(k_phase),
        .hold_v(hold_v), .hold_a(hold_a), .hold_d(hold_d),
        .rd_a(rd_a), .rd_pair(rd_pair)
    );

    qbs_rd_path #(.AW(AW), .W(W)) u_rd (
        .clk(clk), .rst_n(rst_n), .k_phase(k_phase), .addr(addr),
        .rd_sel_n(rd_sel_n), .rd_a(rd_a), .rd_pair(rd_pair),
        .rdata(rdata), .rvalid(rvalid)
    );

    logic [2:0] chk_age;
    always_ff @(posedge clk) begin
        if (!rst_n)              chk_age <= '0;
        else if (chk_age != 3'd7) chk_age <= chk_age + 3'd1;
    end

    // R3
    phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_age != 3'd0) |-> (k_phase != $past(k_phase)));

    // R4
    rd_beat0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_age >= 3'd4 && $past(k_phase, 4) && !$past(rd_sel_n, 4)) |-> rvalid);

    // R4
    rd_beat1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_age >= 3'd5 && $past(k_phase, 5) && !$past(rd_sel_n, 5)) |-> rvalid);

    // R2
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_age >= 3'd4 && $past(k_phase, 4) && $past(rd_sel_n, 4)) |-> !rvalid);

endmodule

// File: tb/sim_qdr_burst_sram.sv
module sim_qdr_burst_sram;
    localparam int AW = 3;
    localparam int W  = 9;
    localparam int N  = 1 << AW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          k_phase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic          rvalid;

    qdr_burst_sram #(.AW(AW), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .k_phase(k_phase), .addr(addr),
        .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [2*W-1:0] ref_m [N];
    int             due_q[$];
    logic [W-1:0]   dat_q[$];
    string          tag_q[$];

    bit            pend = 1'b0;
    int            pend_a = 0;
    logic [W-1:0]  pend_d0 = '0;
    logic [W-1:0]  pend_d1 = '0;
    int            wcnt = 0;
    int            prev_wa = 0;

    task automatic chk(input string tag, input bit ok, input logic [W:0] act, input logic [W:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mk0(int a, int n);
        return W'((a * 37 + n * 11 + 5) % 512);
    endfunction

    function automatic logic [W-1:0] mk1(int a, int n);
        return W'((a * 53 + n * 29 + 200) % 512);
    endfunction

    // one memory cycle: K phase then K# phase
    task automatic kcycle(input bit rd, input int ra, input bit wr, input int wa,
                          input string tag, input bit noise);
        string t;
        bit    hit;
        logic [W-1:0] d0, d1;
        @(negedge clk);
        k_phase  = 1'b1;
        addr     = AW'(ra);
        rd_sel_n = !rd;
        wr_sel_n = !noise;               // R3: write select on K edge is ignored
        hit = 1'b0;
        if (pend) begin
            wdata = pend_d1;
            ref_m[pend_a] = {pend_d1, pend_d0};
            hit = (pend_a == ra);
            pend = 1'b0;
        end else begin
            wdata = noise ? W'(9'h1AB) : '0;
        end
        if (rd) begin
            t = tag;
            if (t == "") begin
                if (hit)                  t = "R6 bypass";
                else if (wr && wa == ra)  t = "R7 later write";
                else                      t = "R8 concurrent";
            end
            due_q.push_back(cyc + 4); dat_q.push_back(ref_m[ra][W-1:0]);   tag_q.push_back({t, " beat0"});
            due_q.push_back(cyc + 5); dat_q.push_back(ref_m[ra][2*W-1:W]); tag_q.push_back({t, " beat1"});
        end
        @(negedge clk);
        k_phase  = 1'b0;
        rd_sel_n = !noise;               // R2: read select on K# edge is ignored
        wr_sel_n = !wr;
        if (wr) begin
            d0 = mk0(wa, wcnt);
            d1 = mk1(wa, wcnt);
            wcnt++;
            addr    = AW'(wa);
            wdata   = d0;
            pend    = 1'b1;
            pend_a  = wa;
            pend_d0 = d0;
            pend_d1 = d1;
        end else begin
            addr  = AW'(ra + 1);
            wdata = W'(9'h0F0);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                chk(tag_q[0], rvalid && (rdata == dat_q[0]), {rvalid, rdata}, {1'b1, dat_q[0]});
                void'(due_q.pop_front());
                void'(dat_q.pop_front());
                void'(tag_q.pop_front());
            end else if (rvalid) begin
                chk("R2 R4 unexpected rvalid", 1'b0, {rvalid, rdata}, {1'b0, rdata});
            end
        end
    end

    initial begin
        repeat (3) kcycle(0, 0, 0, 0, "", 0);
        rst_n = 1'b1;
        // R1
        chk("R1 reset rvalid", rvalid == 1'b0, {W'(0), rvalid}, '0);
        chk("R1 reset rdata", rdata == '0, {1'b0, rdata}, '0);
        kcycle(0, 0, 0, 0, "", 0);
        kcycle(0, 0, 0, 0, "", 0);
        chk("R1 idle rvalid", rvalid == 1'b0, {W'(0), rvalid}, '0);

        // fill every location with select noise on the wrong phases (R2, R3)
        for (int a = 0; a < N; a++) kcycle(0, (a + 3) % N, 1, a, "", 1);
        kcycle(0, 0, 0, 0, "", 0);
        kcycle(0, 0, 0, 0, "", 0);

        // isolated reads: latency, beat order, noise had no effect
        for (int a = 0; a < N; a++) begin
            kcycle(1, a, 0, 0, "R3 R4 R5 isolated", 0);
            kcycle(0, 0, 0, 0, "", 0);
            kcycle(0, 0, 0, 0, "", 0);
        end

        // every read/write address pair in consecutive cycles
        for (int i = 0; i < N * N; i++) kcycle(1, i % N, 1, (i % N + i / N) % N, "", 0);

        // read the address whose write completes on the same edge
        prev_wa = 0;
        for (int i = 0; i < 2 * N; i++) begin
            kcycle(1, prev_wa, 1, (i * 5 + 2) % N, "", 0);
            prev_wa = (i * 5 + 2) % N;
        end
        kcycle(0, 0, 0, 0, "", 0);
        kcycle(0, 0, 0, 0, "", 0);

        // back-to-back reads only
        for (int a = 0; a < 4; a++) kcycle(1, (a * 3) % N, 0, 0, "R9 back-to-back", 0);
        repeat (6) kcycle(0, 0, 0, 0, "", 0);

        chk("R4 all beats delivered", due_q.size() == 0, (W+1)'(due_q.size()), '0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule